// File: doc/BRIEF.md
# Event-Selectable Performance Counter Bank

This block keeps four 32-bit event counters for a processor core. Two mode registers hold a select code for each counter; every cycle the core presents three small increment amounts (elapsed processor cycles, completed loads/stores and completed floating-point instructions). Each counter adds the one amount its select code chooses, or holds.

Which events a counter may count depends on the counter. Every counter can count cycles. Counter 1 can also count loads/stores, and counter 2 can also count floating-point instructions. Counters are numbered 0 to 3.

A sticky monitor request is raised when a counter's top bit becomes set while its enable is on. Counter 0 has its own enable, and counters 1 to 3 share a second one. Software reads and writes the counters and mode registers through a plain register port. The request stays high until the clear input is pulsed.

Top module: `perf_counter_bank`

## Requirements
- R1: After reset every counter reads 0, both mode registers read 0 and `irq_req` is low.
- R2: The address map is: 0 to 3 for counters 0 to 3, 4 for mode register A and 5 for mode register B. Mode A holds sel0 in bits [3:0], sel1 in [7:4], the counter-0 enable in bit 8 and the shared enable in bit 9. Mode B holds sel2 in [3:0] and sel3 in [7:4]. Unused bits read 0. Addresses 6 and 7 read 0, and writes to them change nothing. `reg_rd_data` shows the current registered state combinationally.
- R3: Select code 0 leaves a counter unchanged.
- R4: Select code 1 adds `inc_cycles` to any counter on each clock edge.
- R5: On counter 1, select code 11 adds `inc_ldst`.
- R6: On counter 2, select code 11 adds `inc_fpu`.
- R7: Every other code leaves the counter unchanged. This covers code 11 on counters 0 and 3.
- R8: Counters wrap modulo 2^32. The 8-bit increments are zero-extended and added without saturation.
- R9: A register write to a counter replaces that cycle's increment for that counter.
- R10: `irq_req` is set at the edge where counter 0's updated value has bit 31 set and the counter-0 enable (its updated value) is 1.
- R11: `irq_req` is set at the edge where any of counters 1 to 3 has updated bit 31 set and the shared enable is 1. With both enables at 0 it is never set.
- R12: `irq_req` stays set until `irq_clear` is high at an edge. That edge clears it, even if the set condition also holds in that cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| inc_cycles | input | 8 | Processor cycles elapsed this cycle |
| inc_ldst | input | 8 | Loads/stores completed this cycle |
| inc_fpu | input | 8 | Floating-point instructions completed this cycle |
| reg_wr_en | input | 1 | Register write strobe |
| reg_wr_addr | input | 3 | Register write address |
| reg_wr_data | input | 32 | Register write data |
| reg_rd_addr | input | 3 | Register read address |
| reg_rd_data | output | 32 | Register read data (combinational) |
| irq_clear | input | 1 | Clears the monitor request at the next edge |
| irq_req | output | 1 | Sticky performance-monitor request |

## Verification
Counter increments, register writes and the monitor request all become visible one clock edge after the inputs that cause them. The counters and mode registers show on `reg_rd_data` with no further delay, because the read path is combinational. The bench drives each cycle's inputs shortly before a rising edge. It clears the inputs at the following falling edge and then sweeps every address and `irq_req` within that low phase. Each comparison therefore sees exactly one edge's worth of change against a model stepped once per edge.

// File: rtl/pcb_pkg.sv
package pcb_pkg;
    localparam int NUM_CTR  = 4;
    localparam int SEL_W    = 4;
    localparam int LDST_IDX = 1;
    localparam int FPU_IDX  = 2;
    localparam int ADDR_MODE_A = 4;
    localparam int ADDR_MODE_B = 5;

    localparam logic [SEL_W-1:0] SEL_HOLD = 4'd0;
    localparam logic [SEL_W-1:0] SEL_CYC  = 4'd1;
    localparam logic [SEL_W-1:0] SEL_AUX  = 4'd11;

    typedef struct packed {
        logic             en_shared;
        logic             en_solo;
        logic [SEL_W-1:0] sel1;
        logic [SEL_W-1:0] sel0;
    } mode_a_t;

    typedef struct packed {
        logic [SEL_W-1:0] sel3;
        logic [SEL_W-1:0] sel2;
    } mode_b_t;
endpackage

// File: rtl/pcb_event_mux.sv
module pcb_event_mux
    import pcb_pkg::*;
#(
    parameter int INC_W   = 8,
    parameter int CTR_W   = 32,
    parameter bit HAS_AUX = 1'b0
) (
    input  logic [SEL_W-1:0] sel,
    input  logic [INC_W-1:0] inc_cyc,
    input  logic [INC_W-1:0] inc_aux,
    output logic [CTR_W-1:0] amount
);
    always_comb begin
        amount = '0;
        if (sel == SEL_CYC) begin
            amount = CTR_W'(inc_cyc);
        end else if (HAS_AUX && (sel == SEL_AUX)) begin
            amount = CTR_W'(inc_aux);
        end
    end
endmodule

// File: rtl/pcb_overflow_req.sv
module pcb_overflow_req #(
    parameter int NUM = 4
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [NUM-1:0] msb_next,
    input  logic           en_solo,
    input  logic           en_shared,
    input  logic           clr,
    output logic           req
);
    logic req_d, req_q;
    logic hit;

    always_comb begin
        hit   = (msb_next[0] & en_solo) | ((|msb_next[NUM-1:1]) & en_shared);
        req_d = req_q | hit;
        if (clr) begin
            req_d = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) req_q <= 1'b0;
        else        req_q <= req_d;
    end

    assign req = req_q;

    assert_sticky_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (req_q && !clr) |=> req_q);
    assert_clear_R12: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> !req_q);
    assert_solo_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && msb_next[0] && en_solo) |=> req_q);
    assert_enabled_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && !req_q && !en_solo && !en_shared) |=> !req_q);
endmodule

// File: rtl/perf_counter_bank.sv
module perf_counter_bank
    import pcb_pkg::*;
#(
    parameter int CTR_W  = 32,
    parameter int INC_W  = 8,
    parameter int ADDR_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [INC_W-1:0]  inc_cycles,
    input  logic [INC_W-1:0]  inc_ldst,
    input  logic [INC_W-1:0]  inc_fpu,
    input  logic              reg_wr_en,
    input  logic [ADDR_W-1:0] reg_wr_addr,
    input  logic [CTR_W-1:0]  reg_wr_data,
    input  logic [ADDR_W-1:0] reg_rd_addr,
    output logic [CTR_W-1:0]  reg_rd_data,
    input  logic              irq_clear,
    output logic              irq_req
);
    localparam int MA_W = $bits(mode_a_t);
    localparam int MB_W = $bits(mode_b_t);

    typedef struct packed {
        logic [NUM_CTR-1:0][CTR_W-1:0] ctr;
        mode_a_t                       ma;
        mode_b_t                       mb;
    } bank_t;

    bank_t st_d, st_q;

    logic [NUM_CTR-1:0][SEL_W-1:0] sel;
    logic [NUM_CTR-1:0][CTR_W-1:0] amount;
    logic [NUM_CTR-1:0]            wr_hit;
    logic [NUM_CTR-1:0]            msb_next;

    assign sel[0] = st_q.ma.sel0;
    assign sel[1] = st_q.ma.sel1;
    assign sel[2] = st_q.mb.sel2;
    assign sel[3] = st_q.mb.sel3;

    for (genvar gi = 0; gi < NUM_CTR; gi++) begin : g_ctr
        logic [INC_W-1:0] aux_in;
        if (gi == LDST_IDX) begin : g_ldst
            assign aux_in = inc_ldst;
        end else if (gi == FPU_IDX) begin : g_fpu
            assign aux_in = inc_fpu;
        end else begin : g_none
            assign aux_in = '0;
        end

        pcb_event_mux #(
            .INC_W  (INC_W),
            .CTR_W  (CTR_W),
            .HAS_AUX((gi == LDST_IDX) || (gi == FPU_IDX))
        ) u_mux (
            .sel    (sel[gi]),
            .inc_cyc(inc_cycles),
            .inc_aux(aux_in),
            .amount (amount[gi])
        );

        assign wr_hit[gi]   = reg_wr_en && (reg_wr_addr == ADDR_W'(gi));
        assign msb_next[gi] = st_d.ctr[gi][CTR_W-1];

        assert_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
            (!wr_hit[gi] && sel[gi] == SEL_HOLD) |=> $stable(st_q.ctr[gi]));
        assert_cycles_R4: assert property (@(posedge clk) disable iff (!rst_n)
            (!wr_hit[gi] && sel[gi] == SEL_CYC)
            |=> st_q.ctr[gi] == $past(st_q.ctr[gi]) + CTR_W'($past(inc_cycles)));
        assert_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
            wr_hit[gi] |=> st_q.ctr[gi] == $past(reg_wr_data));
    end

    always_comb begin
        st_d = st_q;
        for (int i = 0; i < NUM_CTR; i++) begin
            st_d.ctr[i] = st_q.ctr[i] + amount[i];
            if (wr_hit[i]) begin
                st_d.ctr[i] = reg_wr_data;
            end
        end
        if (reg_wr_en && reg_wr_addr == ADDR_W'(ADDR_MODE_A)) begin
            st_d.ma = reg_wr_data[MA_W-1:0];
        end
        if (reg_wr_en && reg_wr_addr == ADDR_W'(ADDR_MODE_B)) begin
            st_d.mb = reg_wr_data[MB_W-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        reg_rd_data = '0;
        for (int i = 0; i < NUM_CTR; i++) begin
            if (reg_rd_addr == ADDR_W'(i)) begin
                reg_rd_data = st_q.ctr[i];
            end
        end
        if (reg_rd_addr == ADDR_W'(ADDR_MODE_A)) begin
            reg_rd_data[MA_W-1:0] = st_q.ma;
        end
        if (reg_rd_addr == ADDR_W'(ADDR_MODE_B)) begin
            reg_rd_data[MB_W-1:0] = st_q.mb;
        end
    end

    pcb_overflow_req #(.NUM(NUM_CTR)) u_req (
        .clk      (clk),
        .rst_n    (rst_n),
        .msb_next (msb_next),
        .en_solo  (st_d.ma.en_solo),
        .en_shared(st_d.ma.en_shared),
        .clr      (irq_clear),
        .req      (irq_req)
    );

    assert_modes_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !(reg_wr_en && (reg_wr_addr == ADDR_W'(ADDR_MODE_A) || reg_wr_addr == ADDR_W'(ADDR_MODE_B)))
        |=> $stable(st_q.ma) && $stable(st_q.mb));
endmodule

// File: tb/test_perf_counter_bank.sv
`timescale 1ns/100ps
module test_perf_counter_bank;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  inc_cycles = '0, inc_ldst = '0, inc_fpu = '0;
    logic        reg_wr_en = 1'b0;
    logic [2:0]  reg_wr_addr = '0;
    logic [31:0] reg_wr_data = '0;
    logic [2:0]  reg_rd_addr = '0;
    logic [31:0] reg_rd_data;
    logic        irq_clear = 1'b0;
    logic        irq_req;

    always #4 clk = ~clk;

    perf_counter_bank i_perf_counter_bank (
        .clk(clk), .rst_n(rst_n), .inc_cycles(inc_cycles), .inc_ldst(inc_ldst),
        .inc_fpu(inc_fpu), .reg_wr_en(reg_wr_en), .reg_wr_addr(reg_wr_addr),
        .reg_wr_data(reg_wr_data), .reg_rd_addr(reg_rd_addr),
        .reg_rd_data(reg_rd_data), .irq_clear(irq_clear), .irq_req(irq_req)
    );

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    logic [31:0] m_ctr [4];
    logic [3:0]  m_sel [4];
    logic        m_en0 = 1'b0, m_ensh = 1'b0, m_irq = 1'b0;
    string       ctr_tag [4];
    string       irq_tag = "R1";

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] pick(input int idx, input logic [3:0] s,
                                         input logic [7:0] c, input logic [7:0] l,
                                         input logic [7:0] f);
        if (s == 4'd1) return {24'd0, c};
        if (s == 4'd11 && idx == 1) return {24'd0, l};
        if (s == 4'd11 && idx == 2) return {24'd0, f};
        return 32'd0;
    endfunction

    function automatic logic [31:0] mode_a();
        return {22'd0, m_ensh, m_en0, m_sel[1], m_sel[0]};
    endfunction

    function automatic logic [31:0] mode_b();
        return {24'd0, m_sel[3], m_sel[2]};
    endfunction

    task automatic check_all();
        for (int i = 0; i < 4; i++) begin
            reg_rd_addr = 3'(i);
            #0.4;
            chk(reg_rd_data == m_ctr[i], ctr_tag[i], reg_rd_data, m_ctr[i]);
        end
        reg_rd_addr = 3'd4; #0.4;
        chk(reg_rd_data == mode_a(), "R2", reg_rd_data, mode_a());
        reg_rd_addr = 3'd5; #0.4;
        chk(reg_rd_data == mode_b(), "R2", reg_rd_data, mode_b());
        reg_rd_addr = 3'd6; #0.4;
        chk(reg_rd_data == 32'd0, "R2", reg_rd_data, 32'd0);
        reg_rd_addr = 3'd7; #0.4;
        chk(reg_rd_data == 32'd0, "R2", reg_rd_data, 32'd0);
        chk(irq_req == m_irq, irq_tag, {31'd0, irq_req}, {31'd0, m_irq});
    endtask

    // Called in the low phase; drives one edge's inputs, steps the model, checks.
    task automatic step(input bit we, input logic [2:0] wa, input logic [31:0] wd,
                        input logic [7:0] c, input logic [7:0] l, input logic [7:0] f,
                        input bit clr);
        logic [31:0] nxt [4];
        logic [31:0] a;
        bit solo_hit, shared_hit;
        reg_wr_en = we; reg_wr_addr = wa; reg_wr_data = wd;
        inc_cycles = c; inc_ldst = l; inc_fpu = f; irq_clear = clr;
        for (int i = 0; i < 4; i++) begin
            a = pick(i, m_sel[i], c, l, f);
            nxt[i] = m_ctr[i] + a;
            if (we && wa == 3'(i)) begin
                nxt[i] = wd;
                ctr_tag[i] = "R9";
            end else if (nxt[i] < m_ctr[i]) ctr_tag[i] = "R8";
            else if (m_sel[i] == 4'd0) ctr_tag[i] = "R3";
            else if (m_sel[i] == 4'd1) ctr_tag[i] = "R4";
            else if (m_sel[i] == 4'd11 && i == 1) ctr_tag[i] = "R5";
            else if (m_sel[i] == 4'd11 && i == 2) ctr_tag[i] = "R6";
            else ctr_tag[i] = "R7";
        end
        if (we && wa == 3'd4) begin
            m_ensh = wd[9]; m_en0 = wd[8]; m_sel[1] = wd[7:4]; m_sel[0] = wd[3:0];
        end
        if (we && wa == 3'd5) begin
            m_sel[3] = wd[7:4]; m_sel[2] = wd[3:0];
        end
        for (int i = 0; i < 4; i++) m_ctr[i] = nxt[i];
        solo_hit   = nxt[0][31] && m_en0;
        shared_hit = (nxt[1][31] || nxt[2][31] || nxt[3][31]) && m_ensh;
        if (clr) begin
            m_irq = 1'b0; irq_tag = "R12";
        end else begin
            irq_tag = solo_hit ? "R10" : (shared_hit ? "R11" : "R12");
            m_irq = m_irq | solo_hit | shared_hit;
        end
        @(posedge clk);
        @(negedge clk);
        reg_wr_en = 1'b0; irq_clear = 1'b0;
        inc_cycles = '0; inc_ldst = '0; inc_fpu = '0;
        check_all();
    endtask

    initial begin
        #(8.0 * 200000);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual running expected finished");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd2718));
        for (int i = 0; i < 4; i++) begin
            m_ctr[i] = '0; m_sel[i] = '0; ctr_tag[i] = "R1";
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        check_all();                                   // R1 reset state
        // R2: writes to unmapped addresses change nothing
        step(1'b1, 3'd6, 32'hFFFF_FFFF, 8'd9, 8'd9, 8'd9, 1'b0);
        step(1'b1, 3'd7, 32'hFFFF_FFFF, 8'd9, 8'd9, 8'd9, 1'b0);
        // R4/R5/R6/R7: cycles on 0, ldst on 1, fpu on 2, code 5 on 3
        step(1'b1, 3'd4, {22'd0, 4'd11, 4'd1}, 8'd0, 8'd0, 8'd0, 1'b0);
        step(1'b1, 3'd5, {24'd0, 4'd5, 4'd11}, 8'd3, 8'd4, 8'd5, 1'b0);
        for (int k = 0; k < 4; k++) step(1'b0, 3'd0, 32'd0, 8'(k + 3), 8'(k + 7), 8'(k + 11), 1'b0);
        // R7: code 11 on counters 0 and 3
        step(1'b1, 3'd4, {22'd0, 4'd1, 4'd11}, 8'd2, 8'd2, 8'd2, 1'b0);
        step(1'b1, 3'd5, {24'd0, 4'd11, 4'd1}, 8'd6, 8'd7, 8'd8, 1'b0);
        step(1'b0, 3'd0, 32'd0, 8'd6, 8'd7, 8'd8, 1'b0);
        // R8: wrap of counter 0 counting cycles, enables off
        step(1'b1, 3'd4, {22'd0, 4'd0, 4'd1}, 8'd0, 8'd0, 8'd0, 1'b0);
        step(1'b1, 3'd0, 32'hFFFF_FFFE, 8'd50, 8'd0, 8'd0, 1'b0);
        step(1'b0, 3'd0, 32'd0, 8'd10, 8'd0, 8'd0, 1'b0);
        // R10: counter 0 crosses into bit 31 with its enable on
        step(1'b1, 3'd4, {22'd1, 4'd0, 4'd1}, 8'd0, 8'd0, 8'd0, 1'b0);
        step(1'b1, 3'd0, 32'h7FFF_FFFF, 8'd0, 8'd0, 8'd0, 1'b0);
        step(1'b0, 3'd0, 32'd0, 8'd1, 8'd0, 8'd0, 1'b0);
        // R12: clear wins, then condition re-raises, then clear with counter reset
        step(1'b0, 3'd0, 32'd0, 8'd0, 8'd0, 8'd0, 1'b1);
        step(1'b0, 3'd0, 32'd0, 8'd0, 8'd0, 8'd0, 1'b0);
        step(1'b1, 3'd0, 32'd0, 8'd0, 8'd0, 8'd0, 1'b1);
        step(1'b0, 3'd0, 32'd0, 8'd0, 8'd0, 8'd0, 1'b0);
        // R11: counter 2 sets bit 31 with shared enable off, then on
        step(1'b1, 3'd2, 32'h8000_0000, 8'd0, 8'd0, 8'd0, 1'b0);
        step(1'b1, 3'd4, {22'd2, 4'd0, 4'd0}, 8'd0, 8'd0, 8'd0, 1'b0);
        step(1'b1, 3'd2, 32'd0, 8'd0, 8'd0, 8'd0, 1'b1);
        // constrained random
        for (int n = 0; n < 4000; n++) begin
            logic [31:0] wd;
            logic [2:0]  wa;
            bit          we;
            we = ($urandom_range(0, 7) == 0);
            wa = 3'($urandom_range(0, 7));
            wd = $urandom();
            if (wa == 3'd4 || wa == 3'd5) begin
                wd[3:0] = 4'(($urandom_range(0, 3) == 0) ? $urandom_range(0, 15)
                                                          : ($urandom_range(0, 1) ? 11 : 1));
                wd[7:4] = 4'(($urandom_range(0, 3) == 0) ? $urandom_range(0, 15)
                                                          : ($urandom_range(0, 1) ? 11 : 1));
            end else if ($urandom_range(0, 1) == 1) begin
                wd[31] = 1'b0;
            end
            step(we, wa, wd, 8'($urandom()), 8'($urandom()), 8'($urandom()),
                 ($urandom_range(0, 15) == 0));
        end
        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule